// File: doc/BRIEF.md
# Dual-Panel Program Flash Address Mapper

This block turns a flat program-flash address into a panel select and an offset inside that panel, for a flash array built from two panels of equal size. Each of two address paths is translated this way. One path serves reads. The other serves the program or erase operation that is currently running. Software can request that the two panels trade places in the address space. That request is applied only when no program or erase is running. A request that arrives while the array is busy waits in a pending state. If a program or erase is running and the read falls in the same panel, the block stalls the read. A read that falls in the other panel goes ahead.

The panel order is held by a four-state machine:
- `ORD_DIRECT`: panel 1 is low and panel 2 is high.
- `ORD_CROSSED`: the two panels are exchanged.
- `ORD_DIRECT_WAIT`: direct order is in force and a swap request is waiting for busy to drop.
- `ORD_CROSSED_WAIT`: crossed order is in force and a request to restore direct order is waiting.

The transitions are:
- DIRECT→CROSSED when the request goes high while idle.
- DIRECT→DIRECT_WAIT when the request goes high while busy.
- DIRECT_WAIT→CROSSED when busy drops with the request still high.
- DIRECT_WAIT→DIRECT when the request is withdrawn.
- CROSSED→DIRECT and CROSSED→CROSSED_WAIT are the mirror images of the first two.
- CROSSED_WAIT→DIRECT when busy drops with the request still low.
- CROSSED_WAIT→CROSSED when the request is withdrawn.

With `dual_mode` low, the array has a single panel and the whole range belongs to panel 1.

Top module: `dpanel_addr_map`

## Requirements
- R1: After reset the order is direct: `order_swapped` = 0 and `swap_pending` = 0.
- R2: In dual mode with direct order, an address with MSB 0 selects panel 1 (`*_panel_sel` = 2'b01). An address with MSB 1 selects panel 2 (2'b10).
- R3: In dual mode with crossed order, an address with MSB 0 selects panel 2 and an address with MSB 1 selects panel 1.
- R4: In dual mode the offset equals the address with its MSB cleared. The range is contiguous, so the top address of the lower half lands on the last offset of one panel and the next address lands on offset 0 of the other panel.
- R5: `rd_stall` is 1 exactly when `busy` is 1 and the read and write addresses select the same panel.
- R6: When `busy` is 0 at a clock edge, `order_swapped` takes the value of `swap_req` from the cycle after that edge onwards, and `swap_pending` is 0.
- R7: While `busy` is 1, `order_swapped` does not change. `swap_pending` is 1 in the cycle after any edge where `busy` = 1 and `swap_req` differs from `order_swapped`. A pending change is applied after the first edge with `busy` = 0. It is dropped if `swap_req` returns to the current order first.
- R8: With `dual_mode` = 0, both paths select panel 1, the offset equals the full address, and `order_swapped` reads 0 whatever `swap_req` is.
- R9: Each panel select output is one-hot at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_mode | input | 1 | 1: two panels fitted; 0: single panel |
| swap_req | input | 1 | Requested panel order (1 = crossed) |
| busy | input | 1 | Program or erase in progress |
| rd_addr | input | ADDR_W | Flat read address |
| wr_addr | input | ADDR_W | Flat address of the active program/erase |
| rd_panel_sel | output | 2 | One-hot read panel (bit0 panel 1, bit1 panel 2) |
| rd_offset | output | ADDR_W | Read offset within the selected panel |
| wr_panel_sel | output | 2 | One-hot write panel |
| wr_offset | output | ADDR_W | Write offset within the selected panel |
| rd_stall | output | 1 | Read must wait for the busy operation |
| order_swapped | output | 1 | Panel order currently in force (1 = crossed) |
| swap_pending | output | 1 | An order change is waiting for busy to clear |

## Verification
The embedded properties are evaluated on every cycle. They confirm that the order register never moves while busy and follows the request one edge after an idle cycle. They also confirm that a stall never appears without busy, that single-panel mode always stalls a read during busy, and that the panel selects remain one-hot. Only the bench scenarios can show the actual address arithmetic at the panel boundaries in both orders. The same holds for the withdrawal of a pending request and for the agreement of panel and offset values with an independent model over random traffic.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [1:0] {
        ORD_DIRECT       = 2'd0,
        ORD_DIRECT_WAIT  = 2'd1,
        ORD_CROSSED      = 2'd2,
        ORD_CROSSED_WAIT = 2'd3
    } ord_state_e;

    localparam logic [1:0] SEL_PANEL1 = 2'b01;
    localparam logic [1:0] SEL_PANEL2 = 2'b10;
endpackage

// File: rtl/fpm_order_fsm.sv
module fpm_order_fsm
    import fpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic busy,
    output logic crossed,
    output logic pending
);
    ord_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ORD_DIRECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ORD_DIRECT: begin
                if (swap_req) state_d = busy ? ORD_DIRECT_WAIT : ORD_CROSSED;
            end
            ORD_DIRECT_WAIT: begin
                if (!swap_req)  state_d = ORD_DIRECT;
                else if (!busy) state_d = ORD_CROSSED;
            end
            ORD_CROSSED: begin
                if (!swap_req) state_d = busy ? ORD_CROSSED_WAIT : ORD_DIRECT;
            end
            ORD_CROSSED_WAIT: begin
                if (swap_req)   state_d = ORD_CROSSED;
                else if (!busy) state_d = ORD_DIRECT;
            end
            default: state_d = ORD_DIRECT;
        endcase
    end

    always_comb begin
        crossed = 1'b0;
        pending = 1'b0;
        unique case (state_q)
            ORD_DIRECT:       begin crossed = 1'b0; pending = 1'b0; end
            ORD_DIRECT_WAIT:  begin crossed = 1'b0; pending = 1'b1; end
            ORD_CROSSED:      begin crossed = 1'b1; pending = 1'b0; end
            ORD_CROSSED_WAIT: begin crossed = 1'b1; pending = 1'b1; end
            default:          begin crossed = 1'b0; pending = 1'b0; end
        endcase
    end

    // R7: order frozen while a program/erase runs
    p_order_frozen_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(crossed));

    // R6: idle edge applies the requested order directly
    p_idle_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (crossed == $past(swap_req)) && !pending);

    // R7: a mismatch seen while busy leaves a pending request
    p_pend_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (swap_req != crossed)) |=> pending);
endmodule

// File: rtl/fpm_xlate.sv
module fpm_xlate
    import fpm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dual_mode,
    input  logic              crossed,
    output logic [1:0]        panel_sel,
    output logic [ADDR_W-1:0] offset
);
    localparam int HALF_W = ADDR_W - 1;

    logic upper_half;
    logic to_panel2;

    always_comb begin
        upper_half = addr[ADDR_W-1];
        to_panel2  = dual_mode & (upper_half ^ crossed);
        panel_sel  = to_panel2 ? SEL_PANEL2 : SEL_PANEL1;
        if (dual_mode) offset = {1'b0, addr[HALF_W-1:0]};
        else           offset = addr;
    end
endmodule

// File: rtl/fpm_conflict.sv
module fpm_conflict (
    input  logic [1:0] rd_sel,
    input  logic [1:0] wr_sel,
    input  logic       busy,
    output logic       stall
);
    always_comb begin
        stall = busy & (|(rd_sel & wr_sel));
    end
endmodule

// File: rtl/dpanel_addr_map.sv
module dpanel_addr_map
    import fpm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode,
    input  logic              swap_req,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        rd_panel_sel,
    output logic [ADDR_W-1:0] rd_offset,
    output logic [1:0]        wr_panel_sel,
    output logic [ADDR_W-1:0] wr_offset,
    output logic              rd_stall,
    output logic              order_swapped,
    output logic              swap_pending
);
    localparam int N_PATHS = 2;

    logic              crossed_q;
    logic              pending_q;
    logic [ADDR_W-1:0] path_addr [N_PATHS];
    logic [1:0]        path_sel  [N_PATHS];
    logic [ADDR_W-1:0] path_off  [N_PATHS];

    fpm_order_fsm u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_req (swap_req),
        .busy     (busy),
        .crossed  (crossed_q),
        .pending  (pending_q)
    );

    assign path_addr[0] = rd_addr;
    assign path_addr[1] = wr_addr;

    for (genvar g = 0; g < N_PATHS; g++) begin : g_path
        fpm_xlate #(.ADDR_W(ADDR_W)) u_xlate (
            .addr      (path_addr[g]),
            .dual_mode (dual_mode),
            .crossed   (crossed_q),
            .panel_sel (path_sel[g]),
            .offset    (path_off[g])
        );
    end

    fpm_conflict u_conflict (
        .rd_sel (path_sel[0]),
        .wr_sel (path_sel[1]),
        .busy   (busy),
        .stall  (rd_stall)
    );

    assign rd_panel_sel  = path_sel[0];
    assign rd_offset     = path_off[0];
    assign wr_panel_sel  = path_sel[1];
    assign wr_offset     = path_off[1];
    assign order_swapped = dual_mode & crossed_q;
    assign swap_pending  = dual_mode & pending_q;

    // R5: no stall without an active operation
    p_stall_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> busy);

    // R5: different panels never stall
    p_split_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_panel_sel != wr_panel_sel) |-> !rd_stall);

    // R8: single panel always collides with an active operation
    p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && busy) |-> rd_stall);

    // R9: selects stay one-hot
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_panel_sel) == 1) && ($countones(wr_panel_sel) == 1));
endmodule

// File: tb/dpanel_addr_map_tb_top.sv
module dpanel_addr_map_tb_top;
    localparam int    ADDR_W  = 16;
    localparam time   CLK_PER = 10ns;
    localparam int    MAX_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dual_mode = 1'b1;
    logic              swap_req = 1'b0;
    logic              busy = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [1:0]        rd_panel_sel, wr_panel_sel;
    logic [ADDR_W-1:0] rd_offset, wr_offset;
    logic              rd_stall, order_swapped, swap_pending;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit m_crossed = 1'b0;
    bit m_pending = 1'b0;

    dpanel_addr_map #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .swap_req(swap_req),
        .busy(busy), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .rd_panel_sel(rd_panel_sel), .rd_offset(rd_offset),
        .wr_panel_sel(wr_panel_sel), .wr_offset(wr_offset),
        .rd_stall(rd_stall), .order_swapped(order_swapped),
        .swap_pending(swap_pending)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYC) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, MAX_CYC);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [1:0] exp_sel(logic [ADDR_W-1:0] a, bit dual, bit cr);
        if (!dual) return 2'b01;
        return ((a[ADDR_W-1] == 1'b1) != cr) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_off(logic [ADDR_W-1:0] a, bit dual);
        if (!dual) return a;
        return a % (1 << (ADDR_W-1));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit ecr = dual_mode && m_crossed;
        logic [1:0] er = exp_sel(rd_addr, dual_mode, m_crossed);
        logic [1:0] ew = exp_sel(wr_addr, dual_mode, m_crossed);
        chk({tag, " rd_sel"}, rd_panel_sel, er);
        chk({tag, " rd_off"}, rd_offset, exp_off(rd_addr, dual_mode));
        chk({tag, " wr_sel"}, wr_panel_sel, ew);
        chk({tag, " wr_off"}, wr_offset, exp_off(wr_addr, dual_mode));
        chk({tag, " stall R5"}, rd_stall, busy && (er == ew));
        chk({tag, " order"}, order_swapped, ecr);
        chk({tag, " pending"}, swap_pending, dual_mode && m_pending);
    endtask

    // drive at negedge, check, then advance across one edge updating the model
    task automatic step(string tag, bit dm, bit sr, bit bz,
                        logic [ADDR_W-1:0] ra, logic [ADDR_W-1:0] wa);
        @(negedge clk);
        dual_mode = dm; swap_req = sr; busy = bz; rd_addr = ra; wr_addr = wa;
        #1;
        check_all(tag);
        @(posedge clk);
        if (!bz) begin
            m_crossed = sr;
            m_pending = 1'b0;
        end else begin
            m_pending = (sr != m_crossed);
        end
    endtask

    localparam logic [ADDR_W-1:0] LO_TOP = (1 << (ADDR_W-1)) - 1;
    localparam logic [ADDR_W-1:0] HI_BOT = (1 << (ADDR_W-1));
    localparam logic [ADDR_W-1:0] TOP    = '1;

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 order at reset", order_swapped, 1'b0);
        chk("R1 pending at reset", swap_pending, 1'b0);
        rst_n = 1'b1;

        // R2 / R4 direct order boundaries
        step("R2 lo-top", 1, 0, 0, LO_TOP, HI_BOT);
        chk("R4 last offset", rd_offset, LO_TOP);
        step("R2 hi-bot", 1, 0, 0, HI_BOT, 0);
        chk("R4 first offset", rd_offset, 0);
        step("R2 top", 1, 0, 0, TOP, 16'h0042);

        // R6 swap while idle, R3 crossed order
        step("R6 req", 1, 1, 0, 16'h0010, 16'h9000);
        step("R3 lo", 1, 1, 0, 16'h0010, 16'h9000);
        chk("R3 lo->panel2", rd_panel_sel, 2'b10);
        step("R3 bnd", 1, 1, 0, LO_TOP, HI_BOT);
        step("R3 bnd2", 1, 1, 0, HI_BOT, LO_TOP);

        // R5 stall cases
        step("R5 same", 1, 1, 1, 16'h0100, 16'h0200);
        step("R5 diff", 1, 1, 1, 16'h0100, 16'hC000);
        chk("R5 diff no stall", rd_stall, 1'b0);

        // R7 pending while busy, applied on idle
        step("R7 req busy", 1, 0, 1, 16'h0100, 16'h0200);
        step("R7 hold", 1, 0, 1, 16'h0100, 16'h0200);
        chk("R7 still crossed", order_swapped, 1'b1);
        chk("R7 pending seen", swap_pending, 1'b1);
        step("R7 release", 1, 0, 0, 16'h0100, 16'h0200);
        step("R7 applied", 1, 0, 0, 16'h0100, 16'h0200);
        chk("R7 applied order", order_swapped, 1'b0);

        // R7 withdrawal
        step("R7 wreq", 1, 1, 1, 16'h8000, 16'h0001);
        step("R7 wdraw", 1, 0, 1, 16'h8000, 16'h0001);
        step("R7 wdone", 1, 0, 0, 16'h8000, 16'h0001);
        chk("R7 withdrawn pending", swap_pending, 1'b0);
        step("R7 wafter", 1, 0, 0, 16'h8000, 16'h0001);
        chk("R7 withdrawn order", order_swapped, 1'b0);

        // R8 single panel, swap ignored
        step("R8 a", 0, 1, 0, TOP, 16'h1234);
        step("R8 b", 0, 1, 1, 16'hF00D, 16'h0003);
        chk("R8 stall", rd_stall, 1'b1);
        chk("R8 order", order_swapped, 1'b0);
        step("R8 c", 0, 1, 0, HI_BOT, LO_TOP);

        // random traffic (R2..R9)
        for (int i = 0; i < 400; i++) begin
            step("RND R9", ($urandom % 8) != 0, $urandom % 2, ($urandom % 3) == 0,
                 ADDR_W'($urandom), ADDR_W'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule